// File: doc/BRIEF.md
# In-Band Control Pattern Detector for a One-Bit Audio Stream

This block sits on the one-bit pulse-density audio input of an amplifier and listens for control commands hidden inside the stream itself. A command is an 8-bit word that the source repeats back to back. The block finds the repetition wherever it starts in the bit stream. Once a listed word has repeated long enough, the block decodes it into persistent settings: a standby request, a gain choice, an inverted sample-rate choice, and three mode flags.

The defaults come from a 2-bit strap value that is latched at power-up. Any gain or rate command overrides the strap until a clock-loss indication restores every setting to its strap-derived default. The block mutes the output while a command is on the wire, so that a setting can change in mid-play without a click. A standby command holds the part idle until the stream stops repeating.

Top module: `pdm_wmark_ctrl`

## Requirements
- R1: Detection does not depend on byte alignment. A listed word whose repetition starts at any bit offset is recognised as that word.
- R2: A command takes effect on the first clock edge after the last bit of its 128th copy, counted from a preceding byte that is the bitwise complement of the command. It does not take effect at the edge that consumes that last bit.
- R3: Word 0xAC sets standby_o to 1. standby_o stays 1 while 0xAC keeps repeating.
- R4: In standby, the first bit that differs from the bit 8 cycles earlier clears standby_o. It reads 0 two clocks after that bit is taken.
- R5: Words 0xD8, 0xD4 and 0xD2 set gain_o to 2 (5 V), 1 (3.6 V) and 0 (2.5 V). The choice overrides the strap and persists after the command ends.
- R6: Word 0xD1 sets rate_128x_o to the inverse of strap bit 0.
- R7: Words 0xE1, 0xE2 and 0xE4 set low_emi_o, half_pulse_o and rate_32k_o respectively.
- R8: mute_o is 0 after 7 copies of a listed word and 1 one clock after the 8th copy, counted from a complement byte. mute_o stays 1 for as long as standby_o is 1.
- R9: When the repetition breaks outside standby, mute_o stays 1 for 8 clocks after the breaking bit and is 0 after that.
- R10: A repeated word that is not listed leaves mute_o at 0 and changes no setting.
- R11: A clock-loss pulse returns gain_o and rate_128x_o to their strap defaults and clears standby_o and all mode flags.
- R12: After reset, mute_o and standby_o are 0, the flags are 0, gain_o is 2 if strap bit 1 is 1 (else 1), and rate_128x_o equals strap bit 0.
- R13: A command is applied once per unbroken repetition. Clearing it by clock loss while the same word keeps repeating does not re-apply it. A new repetition after a break does re-apply it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock of the audio stream |
| rst_n_i | input | 1 | Synchronous reset, active low |
| pdm_i | input | 1 | One-bit audio data, sampled each clock |
| strap_i | input | 2 | Latched strap: bit 1 = 5 V gain, bit 0 = 128x rate |
| clk_lost_i | input | 1 | Synchronous clock-loss indication, restores defaults |
| mute_o | output | 1 | Output mute request |
| standby_o | output | 1 | Standby state |
| gain_o | output | 2 | Effective gain code: 0 = 2.5 V, 1 = 3.6 V, 2 = 5 V |
| rate_128x_o | output | 1 | Effective rate select, 1 = 128x |
| low_emi_o | output | 1 | Low-emission modulation mode |
| half_pulse_o | output | 1 | Half-cycle pulse mode |
| rate_32k_o | output | 1 | Special 32 kHz / 128x mode |

## Verification
The stream is driven with each listed word preceded by its complement. This makes the repetition count exact, so the bench can tell 7 copies from 8 for the mute threshold and the 128th copy from the first edge after it for command application. A repeated unlisted word separates periodicity alone from a real command. A word started three bits off its byte boundary shows that recognition does not depend on alignment. Clock-loss pulses given while a word is still repeating separate "cleared and held cleared" from "applied again", and a standby command followed by ordinary audio checks both the exit from standby and the mute release.

// File: rtl/pdmcmd_pkg.sv
// Shared definitions for the in-band command detector.
// Assumes command words are 8 bits wide and that exactly eight words are listed.
package pdmcmd_pkg;

    localparam int CODE_W    = 8;
    localparam int NUM_CODES = 8;

    // Command index; this order is also the index into the code list.
    typedef enum logic [2:0] {
        CMD_STANDBY    = 3'd0,
        CMD_GAIN_HI    = 3'd1,
        CMD_GAIN_MID   = 3'd2,
        CMD_GAIN_LO    = 3'd3,
        CMD_RATE_FLIP  = 3'd4,
        CMD_LOW_EMI    = 3'd5,
        CMD_HALF_PULSE = 3'd6,
        CMD_RATE_32K   = 3'd7
    } cmd_e;

    // Gain code presented on the gain output.
    typedef enum logic [1:0] {
        GAIN_2V5 = 2'd0,
        GAIN_3V6 = 2'd1,
        GAIN_5V0 = 2'd2
    } gain_e;

    // Returns the wire value of a command word for a given index.
    function automatic logic [CODE_W-1:0] cmd_code(input int idx);
        case (idx)
            0:       return 8'hAC;
            1:       return 8'hD8;
            2:       return 8'hD4;
            3:       return 8'hD2;
            4:       return 8'hD1;
            5:       return 8'hE1;
            6:       return 8'hE2;
            default: return 8'hE4;
        endcase
    endfunction

endpackage

// File: rtl/pdmcmd_code_match.sv
// Compares an 8-bit window of the stream against every listed command word.
// Purely combinational. Assumes the listed words are distinct, so at most one matches.
module pdmcmd_code_match
    import pdmcmd_pkg::*;
(
    input  logic [CODE_W-1:0]    win_i,
    output logic                 hit_o,
    output cmd_e                 cmd_o,
    output logic [NUM_CODES-1:0] hit_vec_o
);

    // One equality comparator per listed word.
    for (genvar g = 0; g < NUM_CODES; g++) begin : g_cmp
        assign hit_vec_o[g] = (win_i == cmd_code(g));
    end

    assign hit_o = |hit_vec_o;

    // Encode the matching comparator into a command index.
    always_comb begin
        cmd_o = CMD_STANDBY;
        for (int i = NUM_CODES - 1; i >= 0; i--) begin
            if (hit_vec_o[i]) cmd_o = cmd_e'(3'(i));
        end
    end

endmodule

// File: rtl/pdmcmd_repeat_det.sv
// Finds an 8-periodic stretch of the stream and tracks how long it has lasted.
// Each incoming bit is compared with the bit 8 cycles earlier. Consecutive
// agreements are counted up to a saturation limit, and any disagreement clears
// the count. The last listed word seen in the window during the run is kept.
// Assumes one data bit per clock.
module pdmcmd_repeat_det
    import pdmcmd_pkg::*;
#(
    parameter int REPS      = 128,
    parameter int MUTE_REPS = 8
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic pdm_i,
    output logic rep_full_o,
    output logic mute_arm_o,
    output logic brk_o,
    output logic code_vld_o,
    output cmd_e cmd_o
);

    localparam int RUN_LIM  = (REPS - 1) * CODE_W;
    localparam int MUTE_RUN = (MUTE_REPS - 1) * CODE_W;
    localparam int RUN_W    = $clog2(RUN_LIM + 1);

    logic [CODE_W-1:0]    sr_q;
    logic [CODE_W-1:0]    win;
    logic [RUN_W-1:0]     run_q;
    logic                 period_ok;
    logic                 hit;
    cmd_e                 hit_cmd;
    logic [NUM_CODES-1:0] hit_vec;
    logic                 code_vld_q;
    cmd_e                 cmd_q;
    logic                 brk_q;

    assign win       = {sr_q[CODE_W-2:0], pdm_i};
    assign period_ok = (pdm_i == sr_q[CODE_W-1]);

    pdmcmd_code_match u_match (
        .win_i     (win),
        .hit_o     (hit),
        .cmd_o     (hit_cmd),
        .hit_vec_o (hit_vec)
    );

    // Keep the last eight bits of the stream.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) sr_q <= '0;
        else          sr_q <= win;
    end

    // Count consecutive periodic bits, saturating at the limit.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)                            run_q <= '0;
        else if (!period_ok)                     run_q <= '0;
        else if (run_q != RUN_W'(RUN_LIM))       run_q <= run_q + 1'b1;
    end

    // Remember which listed word the current periodic run carries.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            code_vld_q <= 1'b0;
            cmd_q      <= CMD_STANDBY;
        end else if (!period_ok) begin
            code_vld_q <= 1'b0;
        end else if (hit) begin
            code_vld_q <= 1'b1;
            cmd_q      <= hit_cmd;
        end
    end

    // Flag the clock after a bit that broke the periodicity.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) brk_q <= 1'b0;
        else          brk_q <= !period_ok;
    end

    assign rep_full_o = (run_q == RUN_W'(RUN_LIM));
    assign mute_arm_o = code_vld_q && (run_q >= RUN_W'(MUTE_RUN));
    assign brk_o      = brk_q;
    assign code_vld_o = code_vld_q;
    assign cmd_o      = cmd_q;

    AST_RUN_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        run_q <= RUN_W'(RUN_LIM)); // R2
    AST_ONE_CODE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $onehot0(hit_vec)); // R1
    AST_BREAK_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        brk_q |-> !code_vld_q && !rep_full_o); // R4

endmodule

// File: rtl/pdmcmd_cfg_regs.sv
// Holds the settings that commands change, plus standby and the mute hold timer.
// A command is applied once, when its run first reaches the saturation limit.
// The clock-loss input restores the strap defaults but does not re-arm
// application within the same run.
// Assumes the strap value is static after power-up.
module pdmcmd_cfg_regs
    import pdmcmd_pkg::*;
#(
    parameter int HOLD_CYC = 8
) (
    input  logic       clk_i,
    input  logic       rst_n_i,
    input  logic [1:0] strap_i,
    input  logic       clk_lost_i,
    input  logic       rep_full_i,
    input  logic       mute_arm_i,
    input  logic       brk_i,
    input  logic       code_vld_i,
    input  cmd_e       cmd_i,
    output logic       mute_o,
    output logic       standby_o,
    output logic [1:0] gain_o,
    output logic       rate_128x_o,
    output logic       low_emi_o,
    output logic       half_pulse_o,
    output logic       rate_32k_o
);

    localparam int HOLD_W = $clog2(HOLD_CYC + 1);

    logic              done_q;
    logic              apply;
    logic              standby_q;
    logic              gov_vld_q;
    gain_e             gain_ov_q;
    logic              flip_q;
    logic              emi_q;
    logic              half_q;
    logic              r32_q;
    logic [HOLD_W-1:0] hold_q;
    gain_e             gain_def;

    assign apply = rep_full_i && code_vld_i && !done_q;

    // Mark the current run as consumed until it ends.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)         done_q <= 1'b0;
        else if (!rep_full_i) done_q <= 1'b0;
        else if (apply)       done_q <= 1'b1;
    end

    // Update the settings from commands, standby exit and clock loss.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i || clk_lost_i) begin
            standby_q <= 1'b0;
            gov_vld_q <= 1'b0;
            gain_ov_q <= GAIN_3V6;
            flip_q    <= 1'b0;
            emi_q     <= 1'b0;
            half_q    <= 1'b0;
            r32_q     <= 1'b0;
        end else begin
            if (standby_q && brk_i) standby_q <= 1'b0;
            if (apply) begin
                case (cmd_i)
                    CMD_STANDBY:    standby_q <= 1'b1;
                    CMD_GAIN_HI:    begin gov_vld_q <= 1'b1; gain_ov_q <= GAIN_5V0; end
                    CMD_GAIN_MID:   begin gov_vld_q <= 1'b1; gain_ov_q <= GAIN_3V6; end
                    CMD_GAIN_LO:    begin gov_vld_q <= 1'b1; gain_ov_q <= GAIN_2V5; end
                    CMD_RATE_FLIP:  flip_q <= 1'b1;
                    CMD_LOW_EMI:    emi_q  <= 1'b1;
                    CMD_HALF_PULSE: half_q <= 1'b1;
                    default:        r32_q  <= 1'b1;
                endcase
            end
        end
    end

    // Keep mute up for a fixed number of clocks after the arm condition drops.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)           hold_q <= '0;
        else if (mute_arm_i)    hold_q <= HOLD_W'(HOLD_CYC);
        else if (hold_q != '0)  hold_q <= hold_q - 1'b1;
    end

    assign gain_def     = strap_i[1] ? GAIN_5V0 : GAIN_3V6;
    assign gain_o       = gov_vld_q ? gain_ov_q : gain_def;
    assign rate_128x_o  = strap_i[0] ^ flip_q;
    assign mute_o       = standby_q || (hold_q != '0);
    assign standby_o    = standby_q;
    assign low_emi_o    = emi_q;
    assign half_pulse_o = half_q;
    assign rate_32k_o   = r32_q;

    AST_APPLY_NEEDS_FULL: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(standby_q) |-> $past(rep_full_i) && $past(code_vld_i)); // R2
    AST_STANDBY_EXIT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        standby_q && brk_i |=> !standby_q); // R4
    AST_GAIN_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        gain_o != 2'd3); // R5
    AST_MUTE_ON_ARM: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        mute_arm_i |=> mute_o); // R8
    AST_MUTE_FALL: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $fell(mute_o) |-> !$past(mute_arm_i) && !standby_q); // R9
    AST_CLKLOSS_DEFAULTS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        clk_lost_i |=> !standby_q && !emi_q && !half_q && !r32_q && !flip_q && !gov_vld_q); // R11

endmodule

// File: rtl/pdm_wmark_ctrl.sv
// Top level of the in-band command detector.
// It chains the repetition detector into the settings registers.
// Assumes one stream bit per clock, a synchronous active-low reset and a
// synchronous clock-loss indication.
module pdm_wmark_ctrl
    import pdmcmd_pkg::*;
#(
    parameter int REPS      = 128,
    parameter int MUTE_REPS = 8,
    parameter int HOLD_CYC  = 8
) (
    input  logic       clk_i,
    input  logic       rst_n_i,
    input  logic       pdm_i,
    input  logic [1:0] strap_i,
    input  logic       clk_lost_i,
    output logic       mute_o,
    output logic       standby_o,
    output logic [1:0] gain_o,
    output logic       rate_128x_o,
    output logic       low_emi_o,
    output logic       half_pulse_o,
    output logic       rate_32k_o
);

    logic rep_full;
    logic mute_arm;
    logic brk;
    logic code_vld;
    cmd_e cmd;

    pdmcmd_repeat_det #(
        .REPS      (REPS),
        .MUTE_REPS (MUTE_REPS)
    ) u_det (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .pdm_i      (pdm_i),
        .rep_full_o (rep_full),
        .mute_arm_o (mute_arm),
        .brk_o      (brk),
        .code_vld_o (code_vld),
        .cmd_o      (cmd)
    );

    pdmcmd_cfg_regs #(
        .HOLD_CYC (HOLD_CYC)
    ) u_cfg (
        .clk_i        (clk_i),
        .rst_n_i      (rst_n_i),
        .strap_i      (strap_i),
        .clk_lost_i   (clk_lost_i),
        .rep_full_i   (rep_full),
        .mute_arm_i   (mute_arm),
        .brk_i        (brk),
        .code_vld_i   (code_vld),
        .cmd_i        (cmd),
        .mute_o       (mute_o),
        .standby_o    (standby_o),
        .gain_o       (gain_o),
        .rate_128x_o  (rate_128x_o),
        .low_emi_o    (low_emi_o),
        .half_pulse_o (half_pulse_o),
        .rate_32k_o   (rate_32k_o)
    );

endmodule

// File: tb/pdm_wmark_ctrl_bench.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module pdm_wmark_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pdm = 1'b0;
    logic [1:0] strap = 2'b01;
    logic       clk_lost = 1'b0;
    logic       mute, standby, r128, emi, half, r32;
    logic [1:0] gain;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         finished = 0;

    always #2.5 clk = ~clk;

    pdm_wmark_ctrl u_pdm_wmark_ctrl (
        .clk_i        (clk),
        .rst_n_i      (rst_n),
        .pdm_i        (pdm),
        .strap_i      (strap),
        .clk_lost_i   (clk_lost),
        .mute_o       (mute),
        .standby_o    (standby),
        .gain_o       (gain),
        .rate_128x_o  (r128),
        .low_emi_o    (emi),
        .half_pulse_o (half),
        .rate_32k_o   (r32)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One bit per clock; outputs are read 1 ns after the edge.
    task automatic send_bit(input logic b);
        pdm = b;
        @(posedge clk);
        #1;
    endtask

    task automatic send_head(input logic [7:0] v, input int n);
        for (int i = 7; i > 7 - n; i--) send_bit(v[i]);
    endtask

    task automatic send_tail(input logic [7:0] v, input int k);
        for (int i = k - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic send_copies(input logic [7:0] v, input int n);
        for (int c = 0; c < n; c++) send_head(v, 8);
    endtask

    // Complement preamble, 128 copies, one more bit; the command is then in effect.
    task automatic run_cmd(input logic [7:0] v);
        send_head(~v, 8);
        send_copies(v, 128);
        send_head(v, 1);
        send_tail(v, 7);
    endtask

    task automatic brk_audio(input logic [7:0] v);
        send_head(~v, 8);
        send_copies(8'h70, 2);
    endtask

    task automatic t_reset;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R12", "mute", mute, 0);
        chk("R12", "standby", standby, 0);
        chk("R12", "gain", gain, 1);
        chk("R12", "rate", r128, 1);
        chk("R12", "flags", {emi, half, r32}, 0);
    endtask

    task automatic t_unlisted;
        send_head(8'h8F, 8);
        send_copies(8'h70, 200);
        chk("R10", "mute", mute, 0);
        chk("R10", "gain", gain, 1);
        chk("R10", "rate", r128, 1);
        chk("R10", "standby+flags", {standby, emi, half, r32}, 0);
    endtask

    task automatic t_gain;
        send_head(8'h27, 8);           // complement of 0xD8
        send_copies(8'hD8, 7);
        chk("R8", "mute after 7 copies", mute, 0);
        send_copies(8'hD8, 1);
        send_head(8'hD8, 1);
        chk("R8", "mute after 8 copies", mute, 1);
        send_tail(8'hD8, 7);
        send_copies(8'hD8, 119);       // 128 copies in total
        chk("R2", "gain at 128th copy edge", gain, 1);
        send_head(8'hD8, 1);
        chk("R2", "gain one edge later", gain, 2);
        send_tail(8'hD8, 7);
        send_head(8'h27, 4);           // break
        chk("R9", "mute 4 clocks after break", mute, 1);
        send_tail(8'h27, 4);
        send_copies(8'h70, 1);
        chk("R9", "mute released", mute, 0);
        chk("R5", "gain 5V persists", gain, 2);
        run_cmd(8'hD2);
        chk("R5", "gain 2.5V", gain, 0);
        brk_audio(8'hD2);
        run_cmd(8'hD4);
        chk("R5", "gain 3.6V", gain, 1);
        brk_audio(8'hD4);
    endtask

    task automatic t_rate;
        run_cmd(8'hD2);
        brk_audio(8'hD2);
        run_cmd(8'hD1);
        chk("R6", "rate inverted", r128, 0);
        chk("R5", "gain still 2.5V", gain, 0);
        clk_lost = 1'b1;
        send_head(8'hD1, 1);
        clk_lost = 1'b0;
        send_tail(8'hD1, 7);
        chk("R11", "rate default", r128, 1);
        chk("R11", "gain default", gain, 1);
        send_copies(8'hD1, 40);
        chk("R13", "no re-apply in same run", r128, 1);
        brk_audio(8'hD1);
        run_cmd(8'hD1);
        chk("R13", "re-apply after break", r128, 0);
        brk_audio(8'hD1);
    endtask

    task automatic t_modes;
        logic [7:0] rot;
        rot = {8'hE1 << 3} | (8'hE1 >> 5);   // starts three bits into the word
        run_cmd(rot);
        chk("R1", "rotated word recognised", emi, 1);
        brk_audio(rot);
        run_cmd(8'hE2);
        chk("R7", "half pulse", half, 1);
        brk_audio(8'hE2);
        run_cmd(8'hE4);
        chk("R7", "32k mode", r32, 1);
        chk("R7", "low emi kept", emi, 1);
        brk_audio(8'hE4);
    endtask

    task automatic t_standby;
        run_cmd(8'hAC);
        chk("R3", "standby entered", standby, 1);
        chk("R8", "mute in standby", mute, 1);
        send_copies(8'hAC, 40);
        chk("R3", "standby held", standby, 1);
        send_head(8'h53, 2);           // first bit breaks the repetition
        chk("R4", "standby left", standby, 0);
        send_tail(8'h53, 6);
        send_copies(8'h70, 2);
        chk("R9", "mute released after standby", mute, 0);
    endtask

    task automatic t_clkloss;
        run_cmd(8'hAC);
        chk("R3", "standby again", standby, 1);
        clk_lost = 1'b1;
        send_head(8'hAC, 1);
        clk_lost = 1'b0;
        send_tail(8'hAC, 7);
        chk("R11", "standby cleared", standby, 0);
        chk("R11", "flags cleared", {emi, half, r32}, 0);
        chk("R11", "gain default", gain, 1);
        chk("R11", "rate default", r128, 1);
        send_copies(8'hAC, 20);
        chk("R13", "standby not re-entered", standby, 0);
    endtask

    initial begin
        t_reset;
        t_unlisted;
        t_gain;
        t_rate;
        t_modes;
        t_standby;
        t_clkloss;
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule